// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block joins two ports, A and B, across two independent 9-bit lanes. Each lane carries 8 data bits and one parity bit, so each port is 18 bits wide. Data moves from A to B and from B to A on separate paths. Each path has its own clock, its own latch-enable and one clock-enable per lane. Each path's storage can run in one of three modes: transparent, latched or edge-clocked.

One global mode input selects how parity is handled. With the input low, the block generates parity on the way out and checks parity on the way in. With the input high, it behaves as a plain 18-bit registered transceiver and carries the stored parity bit through unchanged. A second input chooses odd or even parity.

The tri-state pins are split into separate signals. Each direction has an input, a data output and an output-enable output, so that the surrounding pad logic can build the bidirectional bus.

Top module: `parity_xcvr`

## Requirements
- R1: While `rst_n` is low at a rising edge of a path's clock, that path's storage is cleared to all zeros.
- R2: Lane k occupies port bits [9k+8:9k]. Data is in bits [9k+7:9k] and the parity bit is bit 9k+8.
- R3: While a path's latch-enable is high, its output data follows its input in the same cycle, and its storage tracks the input at each clock edge.
- R4: While the latch-enable is low, a rising clock edge with a lane's clock-enable high loads that lane's input into storage. The output shows the loaded value from then on.
- R5: While the latch-enable is low and a lane's clock-enable is low, that lane's stored value and output do not change, whatever the input does.
- R6: When `pass_thru` is 0 (generate mode), the outgoing parity bit is computed from the outgoing 8 data bits. The incoming parity bit has no effect on the output.
- R7: When `odd_sel` is 1, a generated lane holds an odd number of ones across its 9 bits. When `odd_sel` is 0, it holds an even number.
- R8: In generate mode, `err_a[k]` (`err_b[k]`) is 1 exactly when the 9 incoming bits of lane k on port A (B) violate the selected parity. The flag follows the live input combinationally.
- R9: When `pass_thru` is 1, the stored or transparent parity bit is output unchanged and both error vectors are 0.
- R10: `b_oe` equals `oe_ab` and `a_oe` equals `oe_ba`. While an enable is low, the matching data output is all zeros.
- R11: The two directions are independent. Each path's storage responds only to its own clock, latch-enable and clock-enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock of the A-to-B path |
| clk_ba | input | 1 | Clock of the B-to-A path |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| le_ab | input | 1 | A-to-B latch-enable; high means transparent |
| le_ba | input | 1 | B-to-A latch-enable; high means transparent |
| cke_ab | input | 2 | A-to-B clock-enable, one bit per lane |
| cke_ba | input | 2 | B-to-A clock-enable, one bit per lane |
| pass_thru | input | 1 | 1: carry parity through; 0: generate and check |
| odd_sel | input | 1 | 1: odd parity; 0: even parity |
| oe_ab | input | 1 | Enables driving of port B |
| oe_ba | input | 1 | Enables driving of port A |
| a_in | input | 18 | Value received on port A |
| a_out | output | 18 | Value driven onto port A |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | 18 | Value received on port B |
| b_out | output | 18 | Value driven onto port B |
| b_oe | output | 1 | Port B drive enable |
| err_a | output | 2 | Parity error per lane on port A input |
| err_b | output | 2 | Parity error per lane on port B input |

## Verification
A wrong stored lane shows at the output as soon as the latch-enable is low and the enable is high. In pass-through mode all 9 bits of the lane differ. In generate mode the 8 data bits differ, together with a parity bit that matches them. A capture or hold fault is therefore visible in the cycle right after the faulty edge. A fault in transparency, parity sense or error logic is visible combinationally in the same cycle as the stimulus. The reference model compares every output on every clock, so no fault can stay hidden behind a later overwrite.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        LM_TRANSP  = 2'd0,
        LM_CAPTURE = 2'd1,
        LM_HOLD    = 2'd2
    } lane_mode_e;
endpackage

// File: rtl/lane_parity.sv
module lane_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          odd_sel,
    output logic          par
);
    // bit that brings the total count of ones to the selected sense
    always_comb begin
        par = odd_sel;
        for (int i = 0; i < DW; i++) begin
            par = par ^ data[i];
        end
    end
endmodule

// File: rtl/parity_chk.sv
module parity_chk #(
    parameter int LANES = 2,
    parameter int DW    = 8
) (
    input  logic [LANES*(DW+1)-1:0] din,
    input  logic                    pass_thru,
    input  logic                    odd_sel,
    output logic [LANES-1:0]        err
);
    localparam int LW = DW + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic expect_par;
        lane_parity #(.DW(DW)) i_gen (
            .data    (din[g*LW +: DW]),
            .odd_sel (odd_sel),
            .par     (expect_par)
        );
        assign err[g] = !pass_thru && (expect_par != din[g*LW + DW]);
    end
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
    import xcvr_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DW    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    le,
    input  logic [LANES-1:0]        cke,
    input  logic [LANES*(DW+1)-1:0] din,
    input  logic                    pass_thru,
    input  logic                    odd_sel,
    input  logic                    oe,
    output logic [LANES*(DW+1)-1:0] dout
);
    localparam int LW = DW + 1;
    localparam int W  = LANES * LW;

    typedef struct packed {
        logic [W-1:0] word;
    } store_t;

    store_t       st_d, st_q;
    logic [W-1:0] src;
    logic [W-1:0] shaped;

    always_comb begin
        lane_mode_e m;
        st_d = st_q;
        for (int l = 0; l < LANES; l++) begin
            if (le)          m = LM_TRANSP;
            else if (cke[l]) m = LM_CAPTURE;
            else             m = LM_HOLD;
            case (m)
                LM_TRANSP, LM_CAPTURE: st_d.word[l*LW +: LW] = din[l*LW +: LW];
                default:               st_d.word[l*LW +: LW] = st_q.word[l*LW +: LW];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src = le ? din : st_q.word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic gen_par;
        lane_parity #(.DW(DW)) i_gen (
            .data    (src[g*LW +: DW]),
            .odd_sel (odd_sel),
            .par     (gen_par)
        );
        assign shaped[g*LW +: DW]   = src[g*LW +: DW];
        assign shaped[g*LW + DW]    = pass_thru ? src[g*LW + DW] : gen_par;

        assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!le && cke[g]) |=> (st_q.word[g*LW +: LW] == $past(din[g*LW +: LW])));
        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!le && !cke[g]) |=> $stable(st_q.word[g*LW +: LW]));
        assert_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
            le |=> (st_q.word[g*LW +: LW] == $past(din[g*LW +: LW])));
    end

    assign dout = oe ? shaped : '0;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (st_q.word == '0));
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
    parameter int LANES = 2,
    parameter int DW    = 8,
    localparam int W    = LANES * (DW + 1)
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             le_ab,
    input  logic             le_ba,
    input  logic [LANES-1:0] cke_ab,
    input  logic [LANES-1:0] cke_ba,
    input  logic             pass_thru,
    input  logic             odd_sel,
    input  logic             oe_ab,
    input  logic             oe_ba,
    input  logic [W-1:0]     a_in,
    output logic [W-1:0]     a_out,
    output logic             a_oe,
    input  logic [W-1:0]     b_in,
    output logic [W-1:0]     b_out,
    output logic             b_oe,
    output logic [LANES-1:0] err_a,
    output logic [LANES-1:0] err_b
);
    localparam int LW = DW + 1;

    xcvr_dir #(.LANES(LANES), .DW(DW)) i_ab (
        .clk (clk_ab), .rst_n (rst_n), .le (le_ab), .cke (cke_ab),
        .din (a_in), .pass_thru (pass_thru), .odd_sel (odd_sel),
        .oe (oe_ab), .dout (b_out)
    );

    xcvr_dir #(.LANES(LANES), .DW(DW)) i_ba (
        .clk (clk_ba), .rst_n (rst_n), .le (le_ba), .cke (cke_ba),
        .din (b_in), .pass_thru (pass_thru), .odd_sel (odd_sel),
        .oe (oe_ba), .dout (a_out)
    );

    parity_chk #(.LANES(LANES), .DW(DW)) i_chk_a (
        .din (a_in), .pass_thru (pass_thru), .odd_sel (odd_sel), .err (err_a)
    );

    parity_chk #(.LANES(LANES), .DW(DW)) i_chk_b (
        .din (b_in), .pass_thru (pass_thru), .odd_sel (odd_sel), .err (err_b)
    );

    assign b_oe = oe_ab;
    assign a_oe = oe_ba;

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assert_gen_sense_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
            (!pass_thru && oe_ab) |-> ((^b_out[g*LW +: LW]) == odd_sel));
        assert_err_flag_R8: assert property (@(posedge clk_ab) disable iff (!rst_n)
            !pass_thru |-> (err_a[g] == ((^a_in[g*LW +: LW]) != odd_sel)));
    end

    assert_pass_quiet_R9: assert property (@(posedge clk_ab) disable iff (!rst_n)
        pass_thru |-> (err_a == '0 && err_b == '0));
    assert_transp_pass_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (le_ab && oe_ab && pass_thru) |-> (b_out == a_in));
    assert_oe_off_b_R10: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !oe_ab |-> (b_out == '0 && !b_oe));
    assert_oe_off_a_R10: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !oe_ba |-> (a_out == '0 && !a_oe));
endmodule

// File: tb/test_parity_xcvr.sv
module test_parity_xcvr;
    localparam int L  = 2;
    localparam int DW = 8;
    localparam int LW = DW + 1;
    localparam int W  = L * LW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         le_ab = 1'b0, le_ba = 1'b0;
    logic [L-1:0] cke_ab = '0, cke_ba = '0;
    logic         pass_thru = 1'b1, odd_sel = 1'b0;
    logic         oe_ab = 1'b1, oe_ba = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic [L-1:0] err_a, err_b;

    parity_xcvr #(.LANES(L), .DW(DW)) i_parity_xcvr (
        .clk_ab (clk), .clk_ba (clk), .rst_n (rst_n),
        .le_ab (le_ab), .le_ba (le_ba), .cke_ab (cke_ab), .cke_ba (cke_ba),
        .pass_thru (pass_thru), .odd_sel (odd_sel),
        .oe_ab (oe_ab), .oe_ba (oe_ba),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
        .err_a (err_a), .err_b (err_b)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag   = "R1";

    // behavioural reference storage
    logic [W-1:0] m_ab = '0, m_ba = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ab = '0;
            m_ba = '0;
        end else begin
            for (int l = 0; l < L; l++) begin
                if (le_ab || cke_ab[l]) m_ab[l*LW +: LW] = a_in[l*LW +: LW];
                if (le_ba || cke_ba[l]) m_ba[l*LW +: LW] = b_in[l*LW +: LW];
            end
        end
    end

    function automatic int ones(logic [W-1:0] v, int lo, int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += v[lo+i];
        return c;
    endfunction

    function automatic logic [W-1:0] exp_out(logic [W-1:0] live, logic [W-1:0] st,
                                             logic le, logic oe);
        logic [W-1:0] s = le ? live : st;
        logic [W-1:0] r = '0;
        if (!oe) return '0;
        for (int l = 0; l < L; l++) begin
            r[l*LW +: DW] = s[l*LW +: DW];
            if (pass_thru) r[l*LW + DW] = s[l*LW + DW];
            else           r[l*LW + DW] = ((ones(s, l*LW, DW) % 2) == 1) ^ odd_sel;
        end
        return r;
    endfunction

    function automatic logic [L-1:0] exp_err(logic [W-1:0] v);
        logic [L-1:0] e = '0;
        for (int l = 0; l < L; l++)
            e[l] = !pass_thru && ((ones(v, l*LW, LW) % 2) != int'(odd_sel));
        return e;
    endfunction

    task automatic check(string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("b_out", b_out, exp_out(a_in, m_ab, le_ab, oe_ab));
        check("a_out", a_out, exp_out(b_in, m_ba, le_ba, oe_ba));
        check("b_oe", W'(b_oe), W'(oe_ab));
        check("a_oe", W'(a_oe), W'(oe_ba));
        check("err_a", W'(err_a), W'(exp_err(a_in)));
        check("err_b", W'(err_b), W'(exp_err(b_in)));
    endtask

    // mode: 0 transparent, 1 random clocked, 2 hold, 3 anything
    task automatic run(string t, int n, int mode_ab, int mode_ba, bit rnd_oe, bit rnd_par);
        tag = t;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            a_in = W'({$urandom, $urandom});
            b_in = W'({$urandom, $urandom});
            le_ab  = (mode_ab == 0) || (mode_ab == 3 && $urandom_range(0, 3) == 0);
            le_ba  = (mode_ba == 0) || (mode_ba == 3 && $urandom_range(0, 3) == 0);
            cke_ab = (mode_ab == 2) ? '0 : L'($urandom);
            cke_ba = (mode_ba == 2) ? '0 : L'($urandom);
            if (rnd_oe) begin
                oe_ab = $urandom_range(0, 1) == 1;
                oe_ba = $urandom_range(0, 1) == 1;
            end
            if (rnd_par) begin
                pass_thru = $urandom_range(0, 1) == 1;
                odd_sel   = $urandom_range(0, 1) == 1;
            end
            @(posedge clk);
            #2;
            compare_all();
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset with random traffic, storage must read zero
        rst_n = 1'b0;
        run("R1", 4, 1, 1, 0, 0);
        rst_n = 1'b1;
        // R2 R3 R9: transparent pass-through, lane layout preserved
        pass_thru = 1'b1;
        run("R2/R3/R9", 40, 0, 0, 0, 0);
        // R6 R7 R8: generate mode, even then odd
        pass_thru = 1'b0; odd_sel = 1'b0;
        run("R6/R7/R8", 40, 0, 0, 0, 0);
        odd_sel = 1'b1;
        run("R6/R7/R8", 40, 0, 0, 0, 0);
        // R4 R5: clocked with random per-lane enables
        run("R4/R5", 60, 1, 1, 0, 1);
        // R5: latched hold, inputs toggle freely
        run("R5", 30, 2, 2, 0, 1);
        // R10: random enables
        run("R10", 40, 3, 3, 1, 1);
        // R11: one path transparent, the other held
        oe_ab = 1'b1; oe_ba = 1'b1;
        run("R11", 30, 0, 2, 0, 1);
        run("R11", 30, 2, 1, 0, 1);
        // R1: reset mid-run after storage was filled
        rst_n = 1'b0;
        run("R1", 2, 1, 1, 0, 1);
        rst_n = 1'b1;
        run("R1", 5, 2, 2, 0, 1);
        run("R11", 200, 3, 3, 1, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule